// File: doc/BRIEF.md
# CAN controller register and interrupt unit

This unit is the byte-wide register front end of a CAN controller. It holds the control registers that software sees and turns command writes into single-cycle strobes for the neighbouring transmit and receive-buffer blocks. It keeps a count of the messages waiting in the receive buffer and drives a level interrupt line.

The unit offers two register layouts: a compact basic layout and a richer extended layout. Bit 7 of the clock-divider byte selects the layout. That byte sits at address 31 in both layouts. The layout in force decides how every read, every write, the interrupt computation and the acceptance of incoming messages behave.

The neighbouring blocks report each stored frame on `rx_frame` and each buffer overflow they detect on `rx_overrun`. Bit timing, output control, acceptance filtering, the message buffers and error counting live outside this unit. Their addresses read as zero here.

Top module: `can_regif`

## Requirements
- R1: Bit 7 of the clock-divider byte (address 31 in either layout) selects the extended layout. In the extended layout, address 0 is mode, 1 is command, 2 is status, 3 is interrupt and 4 is interrupt enable. In the basic layout, address 0 is control, 1 is command, 2 is status and 3 is interrupt.
- R2: A hardware reset (`rst` high) sets the following values. Mode = 0x01, extended status = 0x3C, both interrupt registers = 0x00, interrupt enable = 0x00, clock divider = 0x00, control = 0x01, basic status = 0x0C. It also zeroes the message count and drives `irq`, `tx_req` and `rx_release` low.
- R3: Mode and control keep only the low five bits of the written byte.
- R4: Clearing bit 0 of mode or control while it is set (leaving reset mode) zeroes the message count. Status bit 0 always reads 1 exactly when the message count is non-zero.
- R5: In the basic layout, a control write with bit 0 clear while control bit 0 is already clear is a software reset. It clears mode bits 0x31 and then sets mode bit 0. It clears extended-status bits 0x37 and then sets 0x34. It zeroes the message count.
- R6: A command write with bit 0 set is a transmit request. `tx_req` pulses for one cycle after the write. The active status gets bits 3 and 2 set and bit 5 cleared, and the active interrupt register gets bit 1 set.
- R7: A command write with bit 2 set releases one message when the count is non-zero. `rx_release` pulses for one cycle after the write and the count drops by one. When the count reaches zero, interrupt bit 0 clears. With a count of zero, the release does nothing.
- R8: A command write with bit 3 set clears status bit 1 (overrun) and interrupt bit 3.
- R9: `rx_frame` in operation mode (bit 0 of the active mode or control clear) adds one to the message count and sets interrupt bit 0. In reset mode it is ignored.
- R10: `rx_overrun`, or `rx_frame` arriving when the count is at its maximum (2^MSG_CNT_W − 1), sets status bit 1 and interrupt bit 3. In that case the count is left unchanged.
- R11: Reading the interrupt register returns its value and clears all of its bits. Bit 0 is set again at once if the message count is non-zero.
- R12: In the extended layout, `irq` is high when interrupt enable AND interrupt is non-zero. In the basic layout, control bits 4:1 enable interrupt bits 3:0. `irq` is registered and follows a register change one cycle later.
- R13: `rdata` is loaded on the edge that samples `rd_en`. The command address reads 0x00. Addresses 5–28 (extended) and 4–29 (basic) belong to other units and read 0x00. Addresses 29–30 (extended) and 30 (basic) read 0xFF.
- R14: Writing the first transmit-buffer byte (address 16 in the extended layout, address 10 in the basic layout) sets status bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| addr | input | 5 | Register byte address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; read side effects happen only with it |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| rx_frame | input | 1 | A received frame was stored by the buffer block |
| rx_overrun | input | 1 | The buffer block dropped a frame for lack of space |
| tx_req | output | 1 | One-cycle transmit request |
| rx_release | output | 1 | One-cycle request to free the oldest stored message |
| ext_map | output | 1 | Extended layout selected |
| reset_mode | output | 1 | Active layout is in reset mode |
| irq | output | 1 | Level interrupt, registered |

## Verification
The bench builds the unit with MSG_CNT_W = 2, so the message counter saturates after three frames. A fourth frame then reaches the counter-full overrun path within a few cycles, and three releases drain the counter back to zero. That makes the clearing of the receive interrupt at zero, its re-assertion on an interrupt read and the software reset with messages pending all reachable in a short directed run, in both register layouts.

// File: rtl/can_regif_pkg.sv
package can_regif_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;

  // Register addresses (both layouts share 0..3 and 31)
  localparam logic [ADDR_W-1:0] A_CTRL      = 5'd0;
  localparam logic [ADDR_W-1:0] A_CMD       = 5'd1;
  localparam logic [ADDR_W-1:0] A_STAT      = 5'd2;
  localparam logic [ADDR_W-1:0] A_INT       = 5'd3;
  localparam logic [ADDR_W-1:0] A_IEN       = 5'd4;
  localparam logic [ADDR_W-1:0] A_TXB0_X    = 5'd16;
  localparam logic [ADDR_W-1:0] A_TXB0_B    = 5'd10;
  localparam logic [ADDR_W-1:0] A_ZERO_X    = 5'd28;
  localparam logic [ADDR_W-1:0] A_ZERO_B    = 5'd29;
  localparam logic [ADDR_W-1:0] A_CDIV      = 5'd31;

  // Bit positions
  localparam int CDIV_EXT   = 7;
  localparam int RST_BIT    = 0;
  localparam int CMD_TX     = 0;
  localparam int CMD_REL    = 2;
  localparam int CMD_CLROVR = 3;
  localparam int ST_OVR     = 1;
  localparam int ST_TXDONE  = 2;
  localparam int ST_TXFREE  = 3;
  localparam int ST_TXBUSY  = 5;
  localparam int IR_RX      = 0;
  localparam int IR_TX      = 1;
  localparam int IR_OVR     = 3;

  // Reset values
  localparam logic [BYTE_W-1:0] MODE_RST  = 8'h01;
  localparam logic [BYTE_W-1:0] CTRL_RST  = 8'h01;
  localparam logic [BYTE_W-1:0] STX_RST   = 8'h3C;
  localparam logic [BYTE_W-1:0] STB_RST   = 8'h0C;
  localparam logic [BYTE_W-1:0] SOFT_MODE_CLR = 8'h31;
  localparam logic [BYTE_W-1:0] SOFT_ST_CLR   = 8'h37;
  localparam logic [BYTE_W-1:0] SOFT_ST_SET   = 8'h34;

  typedef struct packed {
    logic wr_mode;
    logic wr_ctrl;
    logic wr_cmd;
    logic wr_ien;
    logic wr_cdiv;
    logic wr_txb0;
    logic rd_int;
  } bus_act_t;

  function automatic logic [BYTE_W-1:0] int_next(
      input logic [BYTE_W-1:0] cur, input logic rd_clr, input logic pend,
      input logic tx, input logic store, input logic ovr,
      input logic clr_ovr, input logic drained);
    logic [BYTE_W-1:0] n;
    n = cur;
    if (rd_clr) begin
      n = '0;
      n[IR_RX] = pend;
    end
    if (tx)      n[IR_TX]  = 1'b1;
    if (store)   n[IR_RX]  = 1'b1;
    if (drained) n[IR_RX]  = 1'b0;
    if (ovr)     n[IR_OVR] = 1'b1;
    if (clr_ovr) n[IR_OVR] = 1'b0;
    return n;
  endfunction

  function automatic logic [BYTE_W-1:1] stat_next(
      input logic [BYTE_W-1:1] cur, input logic tx, input logic txb0,
      input logic ovr, input logic clr_ovr);
    logic [BYTE_W-1:1] n;
    n = cur;
    if (tx) begin
      n[ST_TXDONE] = 1'b1;
      n[ST_TXFREE] = 1'b1;
      n[ST_TXBUSY] = 1'b0;
    end
    if (txb0)    n[ST_TXBUSY] = 1'b1;
    if (ovr)     n[ST_OVR]    = 1'b1;
    if (clr_ovr) n[ST_OVR]    = 1'b0;
    return n;
  endfunction

endpackage

// File: rtl/can_regif_decode.sv
module can_regif_decode
  import can_regif_pkg::*;
(
  input  logic              ext,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output bus_act_t          act
);
  always_comb begin
    act         = '0;
    act.wr_mode = wr_en &  ext & (addr == A_CTRL);
    act.wr_ctrl = wr_en & ~ext & (addr == A_CTRL);
    act.wr_cmd  = wr_en & (addr == A_CMD);
    act.wr_ien  = wr_en &  ext & (addr == A_IEN);
    act.wr_cdiv = wr_en & (addr == A_CDIV);
    act.wr_txb0 = wr_en & (addr == (ext ? A_TXB0_X : A_TXB0_B));
    act.rd_int  = rd_en & (addr == A_INT);
  end
endmodule

// File: rtl/can_regif_msgcnt.sv
module can_regif_msgcnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             nz,
  output logic             full
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)        cnt <= '0;
    else if (inc && !dec)  cnt <= cnt + 1'b1;
    else if (dec && !inc)  cnt <= cnt - 1'b1;
  end

  assign nz   = (cnt != '0);
  assign full = (cnt == CNT_MAX);
endmodule

// File: rtl/can_regif_irq.sv
module can_regif_irq
  import can_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ext,
  input  logic [BYTE_W-1:0] ien_x,
  input  logic [BYTE_W-1:0] int_x,
  input  logic [4:1]        ctrl_en,
  input  logic [3:0]        int_b,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ext ? |(ien_x & int_x) : |(ctrl_en & int_b);
  end
endmodule

// File: rtl/can_regif.sv
module can_regif
  import can_regif_pkg::*;
#(
  parameter int MSG_CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [4:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              rx_frame,
  input  logic              rx_overrun,
  output logic              tx_req,
  output logic              rx_release,
  output logic              ext_map,
  output logic              reset_mode,
  output logic              irq
);
  localparam logic [MSG_CNT_W-1:0] CNT_ONE = MSG_CNT_W'(1);

  logic [4:0]        mode_q, ctrl_q;
  logic [BYTE_W-1:1] st_x_q, st_b_q;
  logic [BYTE_W-1:0] ir_x_q, ir_b_q, ier_q, cdr_q;
  logic [MSG_CNT_W-1:0] cnt_q;
  logic cnt_nz, cnt_full;
  bus_act_t act;

  assign ext_map    = cdr_q[CDIV_EXT];
  assign reset_mode = ext_map ? mode_q[RST_BIT] : ctrl_q[RST_BIT];

  can_regif_decode u_dec (
    .ext(ext_map), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .act(act)
  );

  // Events of this cycle
  logic rx_ok, store, ovr, do_tx, do_rel, clr_ovr;
  logic leave_x, leave_b, soft_rst, cnt_clr, drained;

  assign rx_ok    = rx_frame & ~reset_mode;
  assign store    = rx_ok & ~cnt_full;
  assign ovr      = (rx_ok & cnt_full) | rx_overrun;
  assign do_tx    = act.wr_cmd & wdata[CMD_TX];
  assign do_rel   = act.wr_cmd & wdata[CMD_REL] & cnt_nz;
  assign clr_ovr  = act.wr_cmd & wdata[CMD_CLROVR];
  assign leave_x  = act.wr_mode &  mode_q[RST_BIT] & ~wdata[RST_BIT];
  assign leave_b  = act.wr_ctrl &  ctrl_q[RST_BIT] & ~wdata[RST_BIT];
  assign soft_rst = act.wr_ctrl & ~ctrl_q[RST_BIT] & ~wdata[RST_BIT];
  assign cnt_clr  = leave_x | leave_b | soft_rst;
  assign drained  = do_rel & (cnt_q == CNT_ONE) & ~store;

  can_regif_msgcnt #(.CNT_W(MSG_CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(store), .dec(do_rel),
    .cnt(cnt_q), .nz(cnt_nz), .full(cnt_full)
  );

  // Next values of the active layout's interrupt and status registers
  logic [BYTE_W-1:0] ir_act, ir_nx, st_soft;
  logic [BYTE_W-1:1] st_act, st_nx;

  assign ir_act = ext_map ? ir_x_q : ir_b_q;
  assign st_act = ext_map ? st_x_q : st_b_q;
  assign ir_nx  = int_next(ir_act, act.rd_int, cnt_nz, do_tx, store, ovr,
                           clr_ovr, drained);
  assign st_nx  = stat_next(st_act, do_tx, act.wr_txb0, ovr, clr_ovr);
  assign st_soft = ({st_x_q, 1'b0} & ~SOFT_ST_CLR) | SOFT_ST_SET;

  // Read multiplexer
  logic [BYTE_W-1:0] rd_mux;
  always_comb begin
    if (addr == A_CDIV) begin
      rd_mux = cdr_q;
    end else if (ext_map) begin
      case (addr)
        A_CTRL:  rd_mux = {3'b000, mode_q};
        A_CMD:   rd_mux = '0;
        A_STAT:  rd_mux = {st_x_q, cnt_nz};
        A_INT:   rd_mux = ir_x_q;
        A_IEN:   rd_mux = ier_q;
        default: rd_mux = (addr <= A_ZERO_X) ? '0 : '1;
      endcase
    end else begin
      case (addr)
        A_CTRL:  rd_mux = {3'b000, ctrl_q};
        A_CMD:   rd_mux = '0;
        A_STAT:  rd_mux = {st_b_q, cnt_nz};
        A_INT:   rd_mux = ir_b_q;
        default: rd_mux = (addr <= A_ZERO_B) ? '0 : '1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_RST[4:0];
      ctrl_q     <= CTRL_RST[4:0];
      st_x_q     <= STX_RST[BYTE_W-1:1];
      st_b_q     <= STB_RST[BYTE_W-1:1];
      ir_x_q     <= '0;
      ir_b_q     <= '0;
      ier_q      <= '0;
      cdr_q      <= '0;
      tx_req     <= 1'b0;
      rx_release <= 1'b0;
      rdata      <= '0;
    end else begin
      tx_req     <= do_tx;
      rx_release <= do_rel;
      if (rd_en)       rdata <= rd_mux;
      if (act.wr_mode) mode_q <= wdata[4:0];
      else if (soft_rst)
        mode_q <= (mode_q & ~SOFT_MODE_CLR[4:0]) | MODE_RST[4:0];
      if (act.wr_ctrl) ctrl_q <= wdata[4:0];
      if (act.wr_ien)  ier_q  <= wdata;
      if (act.wr_cdiv) cdr_q  <= wdata;
      if (ext_map) begin
        ir_x_q <= ir_nx;
        st_x_q <= st_nx;
      end else begin
        ir_b_q <= ir_nx;
        st_b_q <= st_nx;
        if (soft_rst) st_x_q <= st_soft[BYTE_W-1:1];
      end
    end
  end

  can_regif_irq u_irq (
    .clk(clk), .rst(rst), .ext(ext_map), .ien_x(ier_q), .int_x(ir_x_q),
    .ctrl_en(ctrl_q[4:1]), .int_b(ir_b_q[3:0]), .irq(irq)
  );

endmodule

// File: rtl/can_regif_chk.sv
module can_regif_chk #(
  parameter int MSG_CNT_W = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [4:0]           addr,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [7:0]           wdata,
  input logic [7:0]           rdata,
  input logic                 tx_req,
  input logic                 rx_release,
  input logic                 irq,
  input logic                 ext,
  input logic [7:0]           ier,
  input logic [MSG_CNT_W-1:0] cnt
);
  p_hw_reset_r2: assert property (@(posedge clk)
    rst |=> (!irq && !tx_req && !rx_release && cnt == '0));

  p_tx_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 5'd1 && wdata[0]) |=> tx_req);

  p_no_empty_release_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 5'd1 && wdata[2] && cnt == '0) |=> !rx_release);

  p_cnt_step_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 ||
                             cnt == $past(cnt) - 1'b1 || cnt == '0));

  p_irq_masked_r12: assert property (@(posedge clk) disable iff (rst)
    (ext && ier == 8'h00) |=> !irq);

  p_cmd_reads_zero_r13: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 5'd1) |=> (rdata == 8'h00));
endmodule

bind can_regif can_regif_chk #(.MSG_CNT_W(MSG_CNT_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .tx_req(tx_req), .rx_release(rx_release),
  .irq(irq), .ext(ext_map), .ier(ier_q), .cnt(cnt_q)
);

// File: tb/sim_can_regif.sv
`timescale 1ns/1ps
module sim_can_regif;
  localparam int CW = 2;
  localparam int NV = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rx_frame = 1'b0, rx_overrun = 1'b0;
  logic tx_req, rx_release, ext_map, reset_mode, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic seen_tx, seen_rel;
  logic [7:0] rv;

  always #10 clk = ~clk;  // 50 MHz

  can_regif #(.MSG_CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rx_frame(rx_frame),
    .rx_overrun(rx_overrun), .tx_req(tx_req), .rx_release(rx_release),
    .ext_map(ext_map), .reset_mode(reset_mode), .irq(irq)
  );

  // {is_write, addr, wdata, expected read}
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 5'd0,  8'h00, 8'h01}, {1'b0, 5'd2,  8'h00, 8'h0C},
    {1'b0, 5'd3,  8'h00, 8'h00}, {1'b0, 5'd31, 8'h00, 8'h00},
    {1'b0, 5'd1,  8'h00, 8'h00}, {1'b0, 5'd30, 8'h00, 8'hFF},
    {1'b0, 5'd12, 8'h00, 8'h00}, {1'b1, 5'd0,  8'hFE, 8'h00},
    {1'b0, 5'd0,  8'h00, 8'h1E}, {1'b1, 5'd31, 8'h80, 8'h00},
    {1'b0, 5'd0,  8'h00, 8'h01}, {1'b0, 5'd2,  8'h00, 8'h3C},
    {1'b0, 5'd29, 8'h00, 8'hFF}, {1'b0, 5'd20, 8'h00, 8'h00},
    {1'b0, 5'd31, 8'h00, 8'h80}, {1'b1, 5'd0,  8'hFF, 8'h00},
    {1'b0, 5'd0,  8'h00, 8'h1F}, {1'b1, 5'd0,  8'h08, 8'h00},
    {1'b0, 5'd0,  8'h00, 8'h08}, {1'b1, 5'd1,  8'h01, 8'h00},
    {1'b0, 5'd2,  8'h00, 8'h1C}, {1'b0, 5'd3,  8'h00, 8'h02},
    {1'b0, 5'd3,  8'h00, 8'h00}, {1'b1, 5'd16, 8'h55, 8'h00},
    {1'b0, 5'd2,  8'h00, 8'h3C}
  };
  string vtag [NV] = '{
    "R2", "R2", "R2", "R2", "R13", "R13", "R13", "R3", "R3", "R1",
    "R1", "R1", "R13", "R13", "R1", "R3", "R3", "R4", "R4", "R6",
    "R6", "R6", "R11", "R14", "R14"
  };

  task automatic chk(input string tag, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    seen_tx = tx_req; seen_rel = rx_release;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic pulse_rx(input bit ovr_only);
    @(negedge clk);
    if (ovr_only) rx_overrun = 1'b1; else rx_frame = 1'b1;
    @(negedge clk);
    rx_overrun = 1'b0; rx_frame = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R2", {7'b0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) wr(VEC[i][20:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][20:16], rv);
        chk(vtag[i], rv, VEC[i][7:0]);
      end
    end

    // Extended layout, operation mode, status 0x3C, empty buffer
    wr(5'd1, 8'h01); chk("R6", {7'b0, seen_tx}, 8'h01);
    idle(1);         chk("R6", {7'b0, tx_req}, 8'h00);
    wr(5'd1, 8'h04); chk("R7", {7'b0, seen_rel}, 8'h00);
    rd(5'd3, rv);    chk("R11", rv, 8'h02);

    pulse_rx(0); pulse_rx(0); pulse_rx(0);
    rd(5'd2, rv);    chk("R9", rv, 8'h1D);
    pulse_rx(0);     // counter full
    rd(5'd2, rv);    chk("R10", rv, 8'h1F);
    rd(5'd3, rv);    chk("R10", rv, 8'h09);
    rd(5'd3, rv);    chk("R11", rv, 8'h01);

    wr(5'd1, 8'h04); chk("R7", {7'b0, seen_rel}, 8'h01);
    rd(5'd2, rv);    chk("R7", rv, 8'h1F);
    wr(5'd1, 8'h04); wr(5'd1, 8'h04);
    rd(5'd3, rv);    chk("R7", rv, 8'h00);
    rd(5'd2, rv);    chk("R7", rv, 8'h1E);

    wr(5'd4, 8'h08); idle(1); chk("R12", {7'b0, irq}, 8'h00);
    pulse_rx(1);     idle(1); chk("R12", {7'b0, irq}, 8'h01);
    wr(5'd1, 8'h08); idle(1); chk("R8", {7'b0, irq}, 8'h00);
    rd(5'd2, rv);    chk("R8", rv, 8'h1C);

    wr(5'd4, 8'h01);
    pulse_rx(0);     idle(1); chk("R12", {7'b0, irq}, 8'h01);
    rd(5'd3, rv);    chk("R11", rv, 8'h01);
    idle(1);         chk("R11", {7'b0, irq}, 8'h01);
    wr(5'd1, 8'h04); idle(1); chk("R7", {7'b0, irq}, 8'h00);

    // Basic layout, control 0x1E
    wr(5'd31, 8'h00); chk("R1", {7'b0, ext_map}, 8'h00);
    pulse_rx(0);     idle(1); chk("R12", {7'b0, irq}, 8'h01);
    wr(5'd1, 8'h04); idle(1); chk("R12", {7'b0, irq}, 8'h00);
    wr(5'd0, 8'h1C); // software reset, receive enable off
    pulse_rx(0);     idle(1); chk("R12", {7'b0, irq}, 8'h00);
    rd(5'd2, rv);    chk("R5", rv, 8'h0D);
    wr(5'd0, 8'h1C); // software reset with one message pending
    rd(5'd2, rv);    chk("R5", rv, 8'h0C);
    wr(5'd31, 8'h80);
    rd(5'd0, rv);    chk("R5", rv, 8'h09);
    rd(5'd2, rv);    chk("R5", rv, 8'h3C);

    // Extended layout, now in reset mode: frames ignored
    chk("R9", {7'b0, reset_mode}, 8'h01);
    pulse_rx(0);
    rd(5'd2, rv);    chk("R9", rv, 8'h3C);
    rd(5'd3, rv);    chk("R9", rv, 8'h00);

    // Hardware reset again
    @(negedge clk); rst = 1'b1;
    idle(2); rst = 1'b0;
    chk("R2", {7'b0, irq}, 8'h00);
    rd(5'd31, rv);   chk("R2", rv, 8'h00);
    rd(5'd0, rv);    chk("R2", rv, 8'h01);
    rd(5'd2, rv);    chk("R2", rv, 8'h0C);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule